// File: doc/BRIEF.md
# Bus Clock Ratio Strobe Generator

This block derives clock-enable strobes for three bus tiers (a wide high-throughput bus, a mid-speed bus and a low-speed register bus) from one source clock. It never makes a new clock. Each tier's logic stays on the source clock and advances only in cycles where its strobe is high. Two independent domains share the generator. The main domain codes every ratio linearly as field plus one, except the mid-speed ratio, which uses a three-value table with one unused code. The peripheral domain codes both dependent ratios as powers of two and also carries a source-select bit.

Each domain is programmed by presenting a 16-bit control word together with that domain's write strobe. A word that holds an unused code is rejected: the domain raises its error flag and keeps the ratios it was using. An accepted word is held back until the next wide-bus strobe, so a strobe period is never cut short. The two dependent strobes can only fire in a cycle where the wide-bus strobe also fires, which keeps all three tiers in phase.

Top module: `bus_ratio_strobe`

## Requirements
- R1: In the peripheral domain, the wide-bus strobe is high once every (F+1) source cycles, where F is control bits 4:0.
- R2: In the main domain, the wide-bus strobe is high once every (F+1) source cycles, where F is control bits 4:0.
- R3: In the main domain, the register-bus strobe fires on every (P+1)-th wide-bus strobe, where P is control bits 14:12.
- R4: In the main domain, control bits 9:8 set the mid-bus ratio: code 0 fires on every wide-bus strobe, code 1 on every 2nd and code 3 on every 4th.
- R5: A main-domain write with code 2 in bits 9:8 is rejected, and main_err is high from the following cycle.
- R6: In the peripheral domain, the mid-bus strobe fires on every 2^H-th wide-bus strobe, where H is bits 9:8 and H is 0, 1 or 2. Code 3 is rejected and raises peri_err from the following cycle.
- R7: In the peripheral domain, the register-bus strobe fires on every 2^Q-th wide-bus strobe, where Q is bits 13:12 (ratio 1, 2, 4 or 8).
- R8: In the peripheral domain, bit 15 of an accepted word appears on peri_src_sel. In the main domain, bit 15 and the bits outside the defined fields are ignored.
- R9: A mid-bus or register-bus strobe is high only in a cycle where the same domain's wide-bus strobe is high.
- R10: A rejected write leaves every ratio and the source select unchanged. A domain's error flag keeps its value until that domain's next write, and an accepted write clears it.
- R11: An accepted word takes effect at the first wide-bus strobe at or after the write. If several words are accepted before that strobe, the last one wins. All dividers of the domain restart at that strobe.
- R12: After reset, every strobe is high in every cycle, both error flags are low and peri_src_sel is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_word | input | 16 | Control word holding the ratio fields |
| main_wr | input | 1 | Write strobe for the main domain |
| peri_wr | input | 1 | Write strobe for the peripheral domain |
| main_axi_en | output | 1 | Main wide-bus clock enable |
| main_ahb_en | output | 1 | Main mid-bus clock enable |
| main_apb_en | output | 1 | Main register-bus clock enable |
| main_err | output | 1 | Main domain rejected its last write |
| peri_axi_en | output | 1 | Peripheral wide-bus clock enable |
| peri_ahb_en | output | 1 | Peripheral mid-bus clock enable |
| peri_apb_en | output | 1 | Peripheral register-bus clock enable |
| peri_err | output | 1 | Peripheral domain rejected its last write |
| peri_src_sel | output | 1 | Peripheral source select from the accepted word |

## Verification
The strobes decode registered counters combinationally, so a strobe is due in the same cycle its counter reaches the terminal value. A written word is sampled at a rising edge. Its ratios show in the strobes from the cycle after the first wide-bus strobe at or after that edge, and the error flag moves in the cycle after the write edge. The bench drives and samples on falling edges only. Its reference model advances once per rising edge, so every one of the nine outputs is compared in every cycle against the exact cycle in which it is due.

// File: rtl/brs_pkg.sv
package brs_pkg;

   typedef enum logic {
      LAYOUT_LINEAR = 1'b0,
      LAYOUT_POW2   = 1'b1
   } layout_e;

   localparam logic [1:0] MAIN_AHB_HOLE = 2'd2;
   localparam logic [1:0] PERI_AHB_HOLE = 2'd3;
   localparam int         AHB_CODE_W    = 2;

   function automatic int unsigned max_apb_ratio(layout_e lay, int unsigned w);
      if (lay == LAYOUT_LINEAR)
         return 32'd1 << w;
      else
         return 32'd1 << ((32'd1 << w) - 1);
   endfunction

endpackage

// File: rtl/brs_field_decode.sv
module brs_field_decode
   import brs_pkg::*;
#(
   parameter layout_e LAYOUT  = LAYOUT_LINEAR,
   parameter int      CTL_W   = 16,
   parameter int      AXI_LSB = 0,
   parameter int      AXI_W   = 5,
   parameter int      AHB_LSB = 8,
   parameter int      APB_LSB = 12,
   parameter int      APB_W   = 3,
   parameter int      SEL_BIT = 15,
   parameter int      RATIO_W = 4
) (
   input  logic [CTL_W-1:0]   word,
   output logic [AXI_W-1:0]   adiv,
   output logic [RATIO_W-1:0] hratio,
   output logic [RATIO_W-1:0] pratio,
   output logic               sel,
   output logic               legal
);

   logic [AHB_CODE_W-1:0] hcode;
   logic [APB_W-1:0]      pcode;

   assign adiv  = word[AXI_LSB +: AXI_W];
   assign hcode = word[AHB_LSB +: AHB_CODE_W];
   assign pcode = word[APB_LSB +: APB_W];

   generate
      if (LAYOUT == LAYOUT_LINEAR) begin : g_linear
         logic unused_bits;
         assign unused_bits = ^word;

         always_comb begin
            legal  = 1'b1;
            hratio = RATIO_W'(1);
            case (hcode)
               2'd0: hratio = RATIO_W'(1);
               2'd1: hratio = RATIO_W'(2);
               2'd3: hratio = RATIO_W'(4);
               default: begin
                  hratio = RATIO_W'(1);
                  legal  = (hcode != MAIN_AHB_HOLE);
               end
            endcase
         end

         assign pratio = RATIO_W'(pcode) + RATIO_W'(1);
         assign sel    = 1'b0;
      end else begin : g_pow2
         logic unused_bits;
         assign unused_bits = ^word;

         assign legal  = (hcode != PERI_AHB_HOLE);
         assign hratio = legal ? (RATIO_W'(1) << hcode) : RATIO_W'(1);
         assign pratio = RATIO_W'(1) << pcode;
         assign sel    = word[SEL_BIT];
      end
   endgenerate

endmodule

// File: rtl/brs_strobe_div.sv
module brs_strobe_div #(
   parameter int RATIO_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               restart,
   input  logic [RATIO_W-1:0] ratio,
   output logic               en
);

   logic [RATIO_W-1:0] cnt_q;
   logic               at_last;

   assign at_last = (cnt_q == (ratio - RATIO_W'(1)));
   assign en      = tick && at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= at_last ? '0 : cnt_q + RATIO_W'(1);
      end
   end

endmodule

// File: rtl/brs_domain.sv
module brs_domain
   import brs_pkg::*;
#(
   parameter layout_e LAYOUT  = LAYOUT_LINEAR,
   parameter int      CTL_W   = 16,
   parameter int      AXI_LSB = 0,
   parameter int      AXI_W   = 5,
   parameter int      AHB_LSB = 8,
   parameter int      APB_LSB = 12,
   parameter int      APB_W   = 3,
   parameter int      SEL_BIT = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CTL_W-1:0] word,
   input  logic             wr,
   output logic             axi_en,
   output logic             ahb_en,
   output logic             apb_en,
   output logic             err,
   output logic             sel
);

   localparam int APB_MAX  = int'(max_apb_ratio(LAYOUT, APB_W));
   localparam int RW_APB   = $clog2(APB_MAX + 1);
   localparam int RATIO_W  = (RW_APB > 3) ? RW_APB : 3;
   localparam int N_DEP    = 2;

   logic [AXI_W-1:0]              dec_adiv;
   logic [RATIO_W-1:0]            dec_h;
   logic [RATIO_W-1:0]            dec_p;
   logic                          dec_sel;
   logic                          dec_ok;
   logic                          wr_ok;

   logic [AXI_W-1:0]              act_adiv_q;
   logic [N_DEP-1:0][RATIO_W-1:0] act_ratio_q;
   logic                          act_sel_q;

   logic [AXI_W-1:0]              pnd_adiv_q;
   logic [N_DEP-1:0][RATIO_W-1:0] pnd_ratio_q;
   logic                          pnd_sel_q;
   logic                          pnd_vld_q;

   logic [AXI_W-1:0]              acnt_q;
   logic                          load;
   logic                          err_q;
   logic [N_DEP-1:0]              dep_en;

   brs_field_decode #(
      .LAYOUT (LAYOUT),
      .CTL_W  (CTL_W),
      .AXI_LSB(AXI_LSB),
      .AXI_W  (AXI_W),
      .AHB_LSB(AHB_LSB),
      .APB_LSB(APB_LSB),
      .APB_W  (APB_W),
      .SEL_BIT(SEL_BIT),
      .RATIO_W(RATIO_W)
   ) u_dec (
      .word  (word),
      .adiv  (dec_adiv),
      .hratio(dec_h),
      .pratio(dec_p),
      .sel   (dec_sel),
      .legal (dec_ok)
   );

   assign wr_ok  = wr && dec_ok;
   assign axi_en = (acnt_q == act_adiv_q);
   assign load   = axi_en && (wr_ok || pnd_vld_q);

   // wide-bus divider and ratio staging
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acnt_q      <= '0;
         act_adiv_q  <= '0;
         act_ratio_q <= {N_DEP{RATIO_W'(1)}};
         act_sel_q   <= 1'b0;
         pnd_adiv_q  <= '0;
         pnd_ratio_q <= {N_DEP{RATIO_W'(1)}};
         pnd_sel_q   <= 1'b0;
         pnd_vld_q   <= 1'b0;
      end else if (axi_en) begin
         acnt_q <= '0;
         if (wr_ok) begin
            act_adiv_q     <= dec_adiv;
            act_ratio_q[0] <= dec_h;
            act_ratio_q[1] <= dec_p;
            act_sel_q      <= dec_sel;
            pnd_vld_q      <= 1'b0;
         end else if (pnd_vld_q) begin
            act_adiv_q  <= pnd_adiv_q;
            act_ratio_q <= pnd_ratio_q;
            act_sel_q   <= pnd_sel_q;
            pnd_vld_q   <= 1'b0;
         end
      end else begin
         acnt_q <= acnt_q + AXI_W'(1);
         if (wr_ok) begin
            pnd_adiv_q     <= dec_adiv;
            pnd_ratio_q[0] <= dec_h;
            pnd_ratio_q[1] <= dec_p;
            pnd_sel_q      <= dec_sel;
            pnd_vld_q      <= 1'b1;
         end
      end
   end

   // error flag follows the verdict on the latest write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         err_q <= 1'b0;
      else if (wr)
         err_q <= !dec_ok;
   end

   generate
      for (genvar g = 0; g < N_DEP; g++) begin : g_dep
         brs_strobe_div #(.RATIO_W(RATIO_W)) u_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (axi_en),
            .restart(load),
            .ratio  (act_ratio_q[g]),
            .en     (dep_en[g])
         );
      end
   endgenerate

   assign ahb_en = dep_en[0];
   assign apb_en = dep_en[1];
   assign err    = err_q;
   assign sel    = act_sel_q;

endmodule

// File: rtl/bus_ratio_strobe.sv
module bus_ratio_strobe
   import brs_pkg::*;
#(
   parameter int CTL_W       = 16,
   parameter int AXI_LSB     = 0,
   parameter int AXI_W       = 5,
   parameter int AHB_LSB     = 8,
   parameter int APB_LSB     = 12,
   parameter int MAIN_APB_W  = 3,
   parameter int PERI_APB_W  = 2,
   parameter int SEL_BIT     = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CTL_W-1:0] ctl_word,
   input  logic             main_wr,
   input  logic             peri_wr,
   output logic             main_axi_en,
   output logic             main_ahb_en,
   output logic             main_apb_en,
   output logic             main_err,
   output logic             peri_axi_en,
   output logic             peri_ahb_en,
   output logic             peri_apb_en,
   output logic             peri_err,
   output logic             peri_src_sel
);

   localparam int MAIN_TOP = APB_LSB + MAIN_APB_W;
   localparam int PERI_TOP = APB_LSB + PERI_APB_W;

   generate
      if (AXI_LSB + AXI_W > CTL_W || AHB_LSB + AHB_CODE_W > CTL_W) begin : g_bad_low
         $error("bus_ratio_strobe: divider field outside the control word");
      end
      if (MAIN_TOP > CTL_W || PERI_TOP > CTL_W || SEL_BIT >= CTL_W) begin : g_bad_high
         $error("bus_ratio_strobe: ratio or select field outside the control word");
      end
      if (PERI_APB_W > 3 || MAIN_APB_W > 8 || AXI_W < 1) begin : g_bad_width
         $error("bus_ratio_strobe: unsupported field width");
      end
   endgenerate

   brs_domain #(
      .LAYOUT (LAYOUT_LINEAR),
      .CTL_W  (CTL_W),
      .AXI_LSB(AXI_LSB),
      .AXI_W  (AXI_W),
      .AHB_LSB(AHB_LSB),
      .APB_LSB(APB_LSB),
      .APB_W  (MAIN_APB_W),
      .SEL_BIT(SEL_BIT)
   ) u_main (
      .clk   (clk),
      .rst_n (rst_n),
      .word  (ctl_word),
      .wr    (main_wr),
      .axi_en(main_axi_en),
      .ahb_en(main_ahb_en),
      .apb_en(main_apb_en),
      .err   (main_err),
      .sel   ()
   );

   brs_domain #(
      .LAYOUT (LAYOUT_POW2),
      .CTL_W  (CTL_W),
      .AXI_LSB(AXI_LSB),
      .AXI_W  (AXI_W),
      .AHB_LSB(AHB_LSB),
      .APB_LSB(APB_LSB),
      .APB_W  (PERI_APB_W),
      .SEL_BIT(SEL_BIT)
   ) u_peri (
      .clk   (clk),
      .rst_n (rst_n),
      .word  (ctl_word),
      .wr    (peri_wr),
      .axi_en(peri_axi_en),
      .ahb_en(peri_ahb_en),
      .apb_en(peri_apb_en),
      .err   (peri_err),
      .sel   (peri_src_sel)
   );

endmodule

// File: rtl/brs_checker.sv
module brs_checker
   import brs_pkg::*;
#(
   parameter int CTL_W   = 16,
   parameter int AHB_LSB = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CTL_W-1:0] ctl_word,
   input logic             main_wr,
   input logic             peri_wr,
   input logic             main_axi_en,
   input logic             main_ahb_en,
   input logic             main_apb_en,
   input logic             main_err,
   input logic             peri_axi_en,
   input logic             peri_ahb_en,
   input logic             peri_apb_en,
   input logic             peri_err,
   input logic             peri_src_sel
);

   logic [1:0] code;
   assign code = ctl_word[AHB_LSB +: 2];

   AST_MAIN_AHB_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      main_ahb_en |-> main_axi_en);  // R9
   AST_MAIN_APB_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      main_apb_en |-> main_axi_en);  // R9
   AST_PERI_AHB_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      peri_ahb_en |-> peri_axi_en);  // R9
   AST_PERI_APB_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      peri_apb_en |-> peri_axi_en);  // R9
   AST_MAIN_HOLE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (main_wr && code == MAIN_AHB_HOLE) |=> main_err);  // R5
   AST_PERI_HOLE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (peri_wr && code == PERI_AHB_HOLE) |=> peri_err);  // R6
   AST_MAIN_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (main_wr && code != MAIN_AHB_HOLE) |=> !main_err);  // R10
   AST_MAIN_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !main_wr |=> $stable(main_err));  // R10
   AST_PERI_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !peri_wr |=> $stable(peri_err));  // R10
   AST_SEL_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      !peri_axi_en |=> $stable(peri_src_sel));  // R11

endmodule

bind bus_ratio_strobe brs_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctl_word    (ctl_word),
   .main_wr     (main_wr),
   .peri_wr     (peri_wr),
   .main_axi_en (main_axi_en),
   .main_ahb_en (main_ahb_en),
   .main_apb_en (main_apb_en),
   .main_err    (main_err),
   .peri_axi_en (peri_axi_en),
   .peri_ahb_en (peri_ahb_en),
   .peri_apb_en (peri_apb_en),
   .peri_err    (peri_err),
   .peri_src_sel(peri_src_sel)
);

// File: tb/sim_bus_ratio_strobe.sv
`timescale 1ns/1ps
module sim_bus_ratio_strobe;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ctl_word = '0;
   logic        main_wr = 1'b0;
   logic        peri_wr = 1'b0;
   logic        main_axi_en, main_ahb_en, main_apb_en, main_err;
   logic        peri_axi_en, peri_ahb_en, peri_apb_en, peri_err, peri_src_sel;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   bus_ratio_strobe u0 (
      .clk, .rst_n, .ctl_word, .main_wr, .peri_wr,
      .main_axi_en, .main_ahb_en, .main_apb_en, .main_err,
      .peri_axi_en, .peri_ahb_en, .peri_apb_en, .peri_err, .peri_src_sel
   );

   // reference model state, index 0 = main, 1 = peripheral
   int a_div[2], a_hr[2], a_pr[2], a_sel[2];
   int p_div[2], p_hr[2], p_pr[2], p_sel[2], p_vld[2];
   int acnt[2], hcnt[2], pcnt[2], m_err[2];

   task automatic model_reset();
      for (int d = 0; d < 2; d++) begin
         a_div[d] = 0; a_hr[d] = 1; a_pr[d] = 1; a_sel[d] = 0;
         p_vld[d] = 0; acnt[d] = 0; hcnt[d] = 0; pcnt[d] = 0; m_err[d] = 0;
      end
   endtask

   task automatic decode(input int d, input logic [15:0] w, output bit ok,
                         output int dv, output int hr, output int pr, output int sl);
      int hc;
      hc = int'(w[9:8]);
      dv = int'(w[4:0]);
      if (d == 0) begin
         ok = (hc != 2);
         hr = (hc == 0) ? 1 : (hc == 1) ? 2 : 4;
         pr = int'(w[14:12]) + 1;
         sl = 0;
      end else begin
         ok = (hc != 3);
         hr = 1 << hc;
         pr = 1 << int'(w[13:12]);
         sl = int'(w[15]);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         model_reset();
      end else begin
         for (int d = 0; d < 2; d++) begin
            bit wr, ok, axi;
            int dv, hr, pr, sl;
            wr = (d == 0) ? main_wr : peri_wr;
            decode(d, ctl_word, ok, dv, hr, pr, sl);
            axi = (acnt[d] == a_div[d]);
            if (axi) begin
               acnt[d] = 0;
               hcnt[d] = (hcnt[d] + 1) % a_hr[d];
               pcnt[d] = (pcnt[d] + 1) % a_pr[d];
               if (wr && ok) begin
                  a_div[d] = dv; a_hr[d] = hr; a_pr[d] = pr; a_sel[d] = sl;
                  p_vld[d] = 0; hcnt[d] = 0; pcnt[d] = 0;
               end else if (p_vld[d] != 0) begin
                  a_div[d] = p_div[d]; a_hr[d] = p_hr[d]; a_pr[d] = p_pr[d];
                  a_sel[d] = p_sel[d]; p_vld[d] = 0; hcnt[d] = 0; pcnt[d] = 0;
               end
            end else begin
               acnt[d] = acnt[d] + 1;
               if (wr && ok) begin
                  p_div[d] = dv; p_hr[d] = hr; p_pr[d] = pr; p_sel[d] = sl;
                  p_vld[d] = 1;
               end
            end
            if (wr) m_err[d] = ok ? 0 : 1;
         end
      end
   end

   task automatic chk(input logic act, input bit exp, input string what);
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s at %0t: actual %0b expected %0b", what, $time, act, exp);
      end
   endtask

   task automatic compare_all();
      bit ax[2], ah[2], ap[2];
      for (int d = 0; d < 2; d++) begin
         ax[d] = (acnt[d] == a_div[d]);
         ah[d] = ax[d] && (hcnt[d] == a_hr[d] - 1);
         ap[d] = ax[d] && (pcnt[d] == a_pr[d] - 1);
      end
      vectors++;
      chk(main_axi_en, ax[0], "R2 R11 main_axi_en");
      chk(main_ahb_en, ah[0], "R4 R9 main_ahb_en");
      chk(main_apb_en, ap[0], "R3 R9 main_apb_en");
      chk(main_err, m_err[0] != 0, "R5 R10 main_err");
      chk(peri_axi_en, ax[1], "R1 R11 peri_axi_en");
      chk(peri_ahb_en, ah[1], "R6 R9 peri_ahb_en");
      chk(peri_apb_en, ap[1], "R7 R9 peri_apb_en");
      chk(peri_err, m_err[1] != 0, "R6 R10 peri_err");
      chk(peri_src_sel, a_sel[1] != 0, "R8 peri_src_sel");
   endtask

   task automatic step(input bit mw, input bit pw, input logic [15:0] w);
      @(negedge clk);
      compare_all();
      main_wr  = mw;
      peri_wr  = pw;
      ctl_word = w;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 16'h0000);
   endtask

   initial begin
      model_reset();
      // R12: reset state, every strobe high, flags low
      repeat (2) begin
         @(negedge clk);
         vectors++;
         chk(main_axi_en & main_ahb_en & main_apb_en, 1'b1, "R12 main strobes");
         chk(peri_axi_en & peri_ahb_en & peri_apb_en, 1'b1, "R12 peri strobes");
         chk(main_err | peri_err | peri_src_sel, 1'b0, "R12 flags");
      end
      rst_n = 1'b1;
      idle(4);
      // main: div 4, mid 2:1, reg bus every 3rd; stray bit 15 ignored (R8)
      step(1'b1, 1'b0, 16'hA103);
      idle(60);
      // main hole code 2 rejected, ratios kept (R5 R10)
      step(1'b1, 1'b0, 16'h0201);
      idle(40);
      // main mid code 3 -> 4:1, clears error (R4 R10)
      step(1'b1, 1'b0, 16'h7300);
      idle(80);
      // peripheral: div 3, mid 4, reg 8, select set (R1 R6 R7 R8)
      step(1'b0, 1'b1, 16'hB202);
      idle(120);
      // peripheral hole code 3 rejected (R6 R10)
      step(1'b0, 1'b1, 16'h0305);
      idle(40);
      // slow divider, then two accepted words before boundary: last wins (R11)
      step(1'b1, 1'b1, 16'h1114);
      idle(3);
      step(1'b0, 1'b1, 16'h2001);
      idle(30);
      step(1'b0, 1'b1, 16'h8106);
      step(1'b0, 1'b1, 16'h0000);
      step(1'b0, 1'b1, 16'h3202);
      idle(60);
      // pseudo-random traffic
      for (int i = 0; i < 4000; i++) begin
         logic [15:0] w;
         bit mw, pw;
         int r;
         r = $urandom % 16;
         w = 16'($urandom);
         w[4:0] = ($urandom % 8 == 0) ? w[4:0] : 5'($urandom % 6);
         mw = (r == 0) || (r == 2);
         pw = (r == 1) || (r == 2);
         step(mw, pw, w);
      end
      idle(20);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule